// File: doc/BRIEF.md
# Presettable Synchronous Counter with Dual Count Enables

This block is a binary up-counter built from identical slices. Each slice holds a small counter register and picks one of four actions on every rising clock edge, highest priority first: clear, parallel load, count up, or hold. Clear and load are synchronous and active-low. Counting needs two active-high enables together: a parallel enable and a trickle enable. Each slice has a terminal-count output. This output is combinational. It is high only when the slice holds its all-ones value and its trickle enable is high. The parallel enable plays no part in it.

The top level chains `STAGES` slices into one wider counter that wraps modulo 2^(SLICE_W*STAGES). A parameter selects how carries pass between slices. In ripple wiring, each slice's terminal count feeds the trickle enable of the next slice. In lookahead wiring, the terminal count of the lowest slice is shared as a parallel enable with every higher slice, and the trickle enables still ripple. Seen at the ports, both wirings act like one wide counter. The lookahead form is meant for designs where the carry path through many slices must stay short.

Top module: `pscnt_chain`

## Requirements
- R1: When `clear_n` is low at a rising edge, `count` becomes 0 on that edge. This holds whatever the values of `load_n`, `cnt_en_p`, `cnt_en_t` and `din`.
- R2: When `clear_n` is high and `load_n` is low at a rising edge, `count` takes the value of `din`. This holds whatever the values of the two enables.
- R3: When `clear_n`, `load_n`, `cnt_en_p` and `cnt_en_t` are all high at a rising edge, `count` increases by one. From all ones it wraps to 0.
- R4: When `clear_n` and `load_n` are high and either enable is low, `count` keeps its value. No slice moves, not even one whose lower slices are at all ones.
- R5: `term_cnt` is high exactly when `cnt_en_t` is high and `count` is all ones. `cnt_en_p` has no effect on it.
- R6: With `LOOKAHEAD` = 0 (ripple wiring) and with `LOOKAHEAD` = 1 (lookahead wiring), `count` follows the same sequence as a single counter of width SLICE_W*STAGES. This includes carries across slice boundaries.
- R7: After an edge that clears or loads the counter, `term_cnt` follows the new value from that same cycle on. A load of all ones with `cnt_en_t` high raises `term_cnt`, and a clear drops it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clear_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en_p | input | 1 | Parallel count enable, active high |
| cnt_en_t | input | 1 | Trickle count enable, active high, gates `term_cnt` |
| din | input | SLICE_W*STAGES | Parallel load data |
| count | output | SLICE_W*STAGES | Counter state |
| term_cnt | output | 1 | High when `count` is all ones and `cnt_en_t` is high |

## Verification
Two wide instances are run side by side, one with ripple wiring and one with lookahead wiring. A first run with both enables held high goes through the whole 8-bit range and past the wrap, so every carry between slices is exercised. A long pseudo-random run then mixes clear, load, both enables and load data on every edge, which tests the priority order against an arithmetic model. Directed cases then cover states where the lower slice is at all ones and only one enable is low. These cases separate correct lookahead gating from a high slice that would step on its own, and they show whether `term_cnt` follows the trickle enable rather than the parallel one.

// File: rtl/pscnt_pkg.sv
package pscnt_pkg;

    typedef enum logic [1:0] {
        ACT_CLEAR = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_COUNT = 2'd2,
        ACT_HOLD  = 2'd3
    } pscnt_act_e;

endpackage

// File: rtl/pscnt_act_sel.sv
module pscnt_act_sel
    import pscnt_pkg::*;
(
    input  logic       clear_n,
    input  logic       load_n,
    input  logic       en_p,
    input  logic       en_t,
    output pscnt_act_e act
);

    // Fixed priority: clear, then load, then count, then hold.
    always_comb begin
        if (!clear_n) begin
            act = ACT_CLEAR;
        end else if (!load_n) begin
            act = ACT_LOAD;
        end else if (en_p && en_t) begin
            act = ACT_COUNT;
        end else begin
            act = ACT_HOLD;
        end
    end

endmodule

// File: rtl/pscnt_slice.sv
module pscnt_slice
    import pscnt_pkg::*;
#(
    parameter int SLICE_W = 4
) (
    input  logic               clk,
    input  logic               clear_n,
    input  logic               load_n,
    input  logic               en_p,
    input  logic               en_t,
    input  logic [SLICE_W-1:0] din,
    output logic [SLICE_W-1:0] q,
    output logic               tc
);

    localparam logic [SLICE_W-1:0] ALL_ONES = '1;
    localparam logic [SLICE_W-1:0] ONE      = SLICE_W'(1);

    typedef struct packed {
        logic [SLICE_W-1:0] cnt;
    } slice_st_t;

    slice_st_t  st_d, st_q;
    pscnt_act_e act;

    pscnt_act_sel u_act_sel (
        .clear_n (clear_n),
        .load_n  (load_n),
        .en_p    (en_p),
        .en_t    (en_t),
        .act     (act)
    );

    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_CLEAR: st_d.cnt = '0;
            ACT_LOAD:  st_d.cnt = din;
            ACT_COUNT: st_d.cnt = st_q.cnt + ONE;
            default:   st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q  = st_q.cnt;
    assign tc = en_t && (st_q.cnt == ALL_ONES);

    // Checks are enabled once the first clear has been seen.
    bit armed_q;
    always_ff @(posedge clk) begin
        if (!clear_n) armed_q <= 1'b1;
    end

    assert_slice_clear_R1: assert property (@(posedge clk) disable iff (!armed_q)
        !clear_n |=> (q == '0));

    assert_slice_load_R2: assert property (@(posedge clk) disable iff (!armed_q)
        (clear_n && !load_n) |=> (q == $past(din)));

    assert_slice_count_R3: assert property (@(posedge clk) disable iff (!armed_q)
        (clear_n && load_n && en_p && en_t) |=> (q == SLICE_W'($past(q) + ONE)));

    assert_slice_hold_R4: assert property (@(posedge clk) disable iff (!armed_q)
        (clear_n && load_n && !(en_p && en_t)) |=> $stable(q));

endmodule

// File: rtl/pscnt_chain.sv
module pscnt_chain #(
    parameter int SLICE_W   = 4,
    parameter int STAGES    = 2,
    parameter bit LOOKAHEAD = 1'b1
) (
    input  logic                        clk,
    input  logic                        clear_n,
    input  logic                        load_n,
    input  logic                        cnt_en_p,
    input  logic                        cnt_en_t,
    input  logic [SLICE_W*STAGES-1:0]   din,
    output logic [SLICE_W*STAGES-1:0]   count,
    output logic                        term_cnt
);

    localparam int TOTAL_W = SLICE_W * STAGES;
    localparam logic [TOTAL_W-1:0] WIDE_ONE = TOTAL_W'(1);

    logic [STAGES-1:0] tc_s;
    logic [STAGES-1:0] ep_s;
    logic [STAGES-1:0] et_s;

    assign ep_s[0] = cnt_en_p;
    assign et_s[0] = cnt_en_t;

    for (genvar k = 1; k < STAGES; k++) begin : g_link
        assign et_s[k] = tc_s[k-1];
        if (LOOKAHEAD) begin : g_look
            // Shared carry from the lowest slice, qualified by the outer enable.
            assign ep_s[k] = cnt_en_p && tc_s[0];
        end else begin : g_ripple
            assign ep_s[k] = cnt_en_p;
        end
    end

    for (genvar k = 0; k < STAGES; k++) begin : g_slice
        pscnt_slice #(
            .SLICE_W (SLICE_W)
        ) u_slice (
            .clk     (clk),
            .clear_n (clear_n),
            .load_n  (load_n),
            .en_p    (ep_s[k]),
            .en_t    (et_s[k]),
            .din     (din[k*SLICE_W +: SLICE_W]),
            .q       (count[k*SLICE_W +: SLICE_W]),
            .tc      (tc_s[k])
        );
    end

    assign term_cnt = tc_s[STAGES-1];

    bit armed_q;
    always_ff @(posedge clk) begin
        if (!clear_n) armed_q <= 1'b1;
    end

    assert_chain_tc_R5: assert property (@(posedge clk) disable iff (!armed_q)
        term_cnt |-> ((&count) && cnt_en_t));

    assert_chain_tc_full_R7: assert property (@(posedge clk) disable iff (!armed_q)
        ((&count) && cnt_en_t) |-> term_cnt);

    assert_chain_step_R6: assert property (@(posedge clk) disable iff (!armed_q)
        (clear_n && load_n && cnt_en_p && cnt_en_t) |=> (count == TOTAL_W'($past(count) + WIDE_ONE)));

    assert_chain_hold_R4: assert property (@(posedge clk) disable iff (!armed_q)
        (clear_n && load_n && !(cnt_en_p && cnt_en_t)) |=> $stable(count));

endmodule

// File: tb/pscnt_chain_bench.sv
module pscnt_chain_bench;

    localparam int SW = 4;
    localparam int NS = 2;
    localparam int W  = SW * NS;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic         clear_n, load_n, en_p, en_t;
    logic [W-1:0] din;
    logic [W-1:0] cnt_la, cnt_rc;
    logic         tc_la, tc_rc;

    pscnt_chain #(.SLICE_W(SW), .STAGES(NS), .LOOKAHEAD(1'b1)) u_pscnt_chain (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en_p(en_p),
        .cnt_en_t(en_t), .din(din), .count(cnt_la), .term_cnt(tc_la));

    pscnt_chain #(.SLICE_W(SW), .STAGES(NS), .LOOKAHEAD(1'b0)) u_pscnt_chain_ripple (
        .clk(clk), .clear_n(clear_n), .load_n(load_n), .cnt_en_p(en_p),
        .cnt_en_t(en_t), .din(din), .count(cnt_rc), .term_cnt(tc_rc));

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] ref_q = '0;
    bit done = 1'b0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(logic c, logic l, logic p, logic t);
        if (!c) return "R1 clear";
        if (!l) return "R2 load";
        if (p && t) return "R3 count";
        return "R4 hold";
    endfunction

    task automatic check_both(string tag);
        chk({tag, " R6 lookahead count"}, cnt_la, ref_q);
        chk({tag, " R6 ripple count"}, cnt_rc, ref_q);
        chk({tag, " R5 lookahead tc"}, tc_la, int'(en_t && (ref_q == '1)));
        chk({tag, " R5 ripple tc"}, tc_rc, int'(en_t && (ref_q == '1)));
    endtask

    // Apply inputs (at a falling edge), clock once, compare at next falling edge.
    task automatic step(logic c, logic l, logic p, logic t, logic [W-1:0] d);
        string tg;
        clear_n = c; load_n = l; en_p = p; en_t = t; din = d;
        #1;
        check_both("pre-edge");
        tg = tag_of(c, l, p, t);
        if (!c)          ref_q = '0;
        else if (!l)     ref_q = d;
        else if (p && t) ref_q = W'(ref_q + 1);
        @(negedge clk);
        check_both(tg);
    endtask

    initial begin
        clear_n = 1'b1; load_n = 1'b1; en_p = 1'b0; en_t = 1'b0; din = '0;
        @(negedge clk);
        // R1: clear with everything else asserted.
        clear_n = 1'b0; load_n = 1'b0; en_p = 1'b1; en_t = 1'b1; din = 8'hA5;
        @(negedge clk);
        ref_q = '0;
        check_both("R1 reset state");

        // R3/R6: full sweep with wrap.
        for (int i = 0; i < 260; i++) step(1, 1, 1, 1, '0);

        // R7: load all ones with only the parallel enable low -> tc high.
        step(1, 0, 0, 1, 8'hFF);
        chk("R7 tc after load ones", tc_la, 1);
        // R5: trickle enable low masks tc.
        step(1, 1, 1, 0, '0);
        chk("R5 tc with trickle low", tc_la, 0);
        // R7: clear drops tc.
        step(0, 1, 1, 1, '0);
        chk("R7 tc after clear", tc_rc, 0);
        // R4: lower slice at ones, parallel enable low -> upper slice holds.
        step(1, 0, 1, 1, 8'h0F);
        step(1, 1, 0, 1, '0);
        chk("R4 upper slice holds", cnt_la, 8'h0F);
        step(1, 1, 1, 0, '0);
        chk("R4 hold trickle low", cnt_rc, 8'h0F);
        // R6: carry across slice boundary.
        step(1, 1, 1, 1, '0);
        chk("R6 boundary carry", cnt_la, 8'h10);
        // R2: load overrides counting.
        step(1, 0, 1, 1, 8'h3C);
        chk("R2 load over count", cnt_rc, 8'h3C);

        // Random mix of controls.
        for (int i = 0; i < 4000; i++) begin
            logic c, l, p, t;
            c = ($urandom_range(0, 15) != 0);
            l = ($urandom_range(0, 7) != 0);
            p = ($urandom_range(0, 3) != 0);
            t = ($urandom_range(0, 3) != 0);
            step(c, l, p, t, W'($urandom_range(0, 255)));
        end
        done = 1'b1;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule